// File: doc/BRIEF.md
# Program Counter Unit

This block holds the 16-bit program counter of an 8051-compatible core and works out every candidate address for the next instruction. Each cycle it adds the instruction length (one to three bytes) to the current value to get the address of the following instruction. Every branch target is formed from that following address, never from the current one.

The decoder supplies a branch command, the operand fields, the accumulator and a take qualifier. The block returns three values: the current PC, the following-instruction address and the selected next PC. The PC register loads the selected next PC only when the step strobe is high. A separate code-address port carries the following address plus the unsigned accumulator, which serves indexed code reads. Fetch, decode and stack handling for calls are done elsewhere.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc` reads 0x0000.
- R2: `pc_seq` equals `pc + len`, wrapping modulo 65536.
- R3: With `br_kind` = 0 (none), `pc_next` equals `pc_seq`.
- R4: With `br_kind` = 1 (relative):
  - when `take` is 1, `pc_next` equals `pc_seq` plus `rel_off` read as a signed 8-bit value (-128..+127), wrapping modulo 65536;
  - when `take` is 0, `pc_next` equals `pc_seq`.
- R5: With `br_kind` = 2 (page absolute), `pc_next` is `{pc_seq[15:11], abs11}`, and `take` has no effect.
- R6: With `br_kind` = 3 (long), `pc_next` equals `abs16`, and `take` has no effect.
- R7: `code_addr` always equals `pc_seq` plus `acc` read as unsigned, modulo 65536. With `br_kind` = 4 (accumulator-indexed read), `pc_next` equals `pc_seq`.
- R8: On a rising clock edge with `step` high, `pc` takes the value `pc_next` had before the edge. With `step` low, `pc` holds its value.
- R9: `br_kind` codes 5, 6 and 7 behave as code 0: `pc_next` equals `pc_seq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Load `pc` from `pc_next` |
| len | input | 2 | Length of the current instruction in bytes, 1 to 3 |
| br_kind | input | 3 | Branch command: 0 none, 1 relative, 2 page absolute, 3 long, 4 accumulator-indexed, 5-7 none |
| take | input | 1 | Branch condition for relative branches |
| rel_off | input | 8 | Signed relative offset |
| abs11 | input | 11 | Low 11 address bits for the page-absolute form |
| abs16 | input | 16 | Full target for the long form |
| acc | input | 8 | Accumulator value |
| pc | output | 16 | Current program counter |
| pc_seq | output | 16 | Address of the following instruction |
| pc_next | output | 16 | Selected next program counter |
| code_addr | output | 16 | Following address plus accumulator |

## Verification
The assertions assume that `len` is never zero on a step cycle, because a zero length would make the PC stall. One assertion checks this input rule directly. The stimulus draws `len` only from 1 to 3 and draws `br_kind` across all eight codes, including the unused ones. The directed cases steer the PC by long branches to the edge of the address space and to the edge of a 2 KB page. This makes wrap-around and the page splice of the 11-bit form happen on purpose rather than by chance.

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int AW = 16,
  parameter int PW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [1:0]    len,
  input  logic [2:0]    br_kind,
  input  logic          take,
  input  logic [DW-1:0] rel_off,
  input  logic [PW-1:0] abs11,
  input  logic [AW-1:0] abs16,
  input  logic [DW-1:0] acc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] pc_seq,
  output logic [AW-1:0] pc_next,
  output logic [AW-1:0] code_addr
);
  localparam int HW = AW - PW;
  localparam logic [2:0] K_REL  = 3'd1;
  localparam logic [2:0] K_PAGE = 3'd2;
  localparam logic [2:0] K_LONG = 3'd3;

  logic [AW-1:0] rel_tgt;

  assign pc_seq    = pc + AW'(len);
  assign rel_tgt   = pc_seq + {{(AW-DW){rel_off[DW-1]}}, rel_off};
  assign code_addr = pc_seq + {{(AW-DW){1'b0}}, acc};

  always_comb begin
    case (br_kind)
      K_REL:   pc_next = take ? rel_tgt : pc_seq;
      K_PAGE:  pc_next = {pc_seq[AW-1:PW], abs11};
      K_LONG:  pc_next = abs16;
      default: pc_next = pc_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pc <= '0;
    else if (step) pc <= pc_next;
  end

  AST_LEN_LEGAL:  assert property (@(posedge clk) disable iff (!rst_n) step |-> len != 2'd0); // R2
  AST_SEQ_DIST:   assert property (@(posedge clk) disable iff (!rst_n) AW'(pc_seq - pc) == AW'(len)); // R2
  AST_NOT_TAKEN:  assert property (@(posedge clk) disable iff (!rst_n) (br_kind == K_REL && !take) |-> pc_next == pc_seq); // R4
  AST_SAME_PAGE:  assert property (@(posedge clk) disable iff (!rst_n) br_kind == K_PAGE |-> pc_next[AW-1:PW] == pc_seq[AW-1:PW]); // R5
  AST_PAGE_LOW:   assert property (@(posedge clk) disable iff (!rst_n) br_kind == K_PAGE |-> pc_next[PW-1:0] == abs11); // R5
  AST_LONG_TGT:   assert property (@(posedge clk) disable iff (!rst_n) br_kind == K_LONG |-> pc_next == abs16); // R6
  AST_IDX_SEQ:    assert property (@(posedge clk) disable iff (!rst_n) br_kind == 3'd4 |-> pc_next == pc_seq); // R7
  AST_IDX_NO_MOVE:assert property (@(posedge clk) disable iff (!rst_n) (step && br_kind == 3'd4) |=> pc != $past(code_addr) || $past(acc) == '0); // R7
  AST_LOAD:       assert property (@(posedge clk) disable iff (!rst_n) step |=> pc == $past(pc_next)); // R8
  AST_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) !step |=> $stable(pc)); // R8
  AST_SPARE_SEQ:  assert property (@(posedge clk) disable iff (!rst_n) br_kind > 3'd4 |-> pc_next == pc_seq); // R9
  AST_HIGH_BITS:  assert property (@(posedge clk) disable iff (!rst_n) br_kind == 3'd0 |-> pc_next == pc_seq); // R3
endmodule

// File: tb/pc_unit_tb_top.sv
module pc_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step = 1'b0;
  logic [1:0] len = 2'd1;
  logic [2:0] br_kind = 3'd0;
  logic take = 1'b0;
  logic [7:0] rel_off = '0;
  logic [10:0] abs11 = '0;
  logic [15:0] abs16 = '0;
  logic [7:0] acc = '0;
  logic [15:0] pc, pc_seq, pc_next, code_addr;

  int checks = 0;
  int fails = 0;
  logic [15:0] pc_m = '0;

  always #4 clk = ~clk;

  pc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .len(len), .br_kind(br_kind),
    .take(take), .rel_off(rel_off), .abs11(abs11), .abs16(abs16), .acc(acc),
    .pc(pc), .pc_seq(pc_seq), .pc_next(pc_next), .code_addr(code_addr)
  );

  function automatic logic [15:0] f_seq(logic [15:0] p, logic [1:0] l);
    return 16'((32'(p) + 32'(l)) % 65536);
  endfunction

  function automatic logic [15:0] f_next(logic [15:0] s, logic [2:0] k, logic t,
                                         logic [7:0] o, logic [10:0] a11, logic [15:0] a16);
    int signed d;
    d = (o >= 8'd128) ? int'(o) - 256 : int'(o);
    case (k)
      3'd1: return t ? 16'((int'(s) + d + 65536) % 65536) : s;
      3'd2: return {s[15:11], a11};
      3'd3: return a16;
      default: return s;
    endcase
  endfunction

  function automatic string f_tag(logic [2:0] k);
    case (k)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(logic s, logic [1:0] l, logic [2:0] k, logic t,
                     logic [7:0] o, logic [10:0] a11, logic [15:0] a16, logic [7:0] a);
    logic [15:0] es, en;
    @(negedge clk);
    check("R8", "pc", pc, pc_m);
    step = s; len = l; br_kind = k; take = t; rel_off = o; abs11 = a11; abs16 = a16; acc = a;
    #1;
    es = f_seq(pc_m, l);
    en = f_next(es, k, t, o, a11, a16);
    check("R2", "pc_seq", pc_seq, es);
    check(f_tag(k), "pc_next", pc_next, en);
    check("R7", "code_addr", code_addr, 16'((32'(es) + 32'(a)) % 65536));
    if (s) pc_m = en;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #1 check("R1", "pc in reset", pc, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1 check("R1", "pc after reset", pc, 16'h0000);
    // R8 hold with no step, even with a long target offered
    cyc(1'b0, 2'd2, 3'd3, 1'b1, 8'h00, 11'h0, 16'hBEEF, 8'h00);
    // R6 long branch to near the top, take ignored
    cyc(1'b1, 2'd3, 3'd3, 1'b0, 8'h00, 11'h0, 16'hFFFE, 8'h10);
    // R2 wrap of following address
    cyc(1'b1, 2'd3, 3'd0, 1'b0, 8'h00, 11'h0, 16'h0, 8'hFF);
    // R4 most negative offset from low address wraps
    cyc(1'b1, 2'd2, 3'd1, 1'b1, 8'h80, 11'h0, 16'h0, 8'h00);
    // R4 most positive offset
    cyc(1'b1, 2'd2, 3'd1, 1'b1, 8'h7F, 11'h0, 16'h0, 8'h00);
    // R4 not taken
    cyc(1'b1, 2'd2, 3'd1, 1'b0, 8'h80, 11'h0, 16'h0, 8'h00);
    // R5 page splice uses following address across a page edge
    cyc(1'b1, 2'd3, 3'd3, 1'b0, 8'h00, 11'h0, 16'h07FE, 8'h00);
    cyc(1'b1, 2'd3, 3'd2, 1'b0, 8'h00, 11'h123, 16'h0, 8'h00);
    cyc(1'b1, 2'd1, 3'd2, 1'b1, 8'h00, 11'h7FF, 16'h0, 8'h00);
    // R7 indexed read leaves PC on the sequential path
    cyc(1'b1, 2'd1, 3'd4, 1'b1, 8'h00, 11'h0, 16'h0, 8'hFF);
    // R9 spare codes
    cyc(1'b1, 2'd2, 3'd5, 1'b1, 8'h40, 11'h55, 16'h1234, 8'h00);
    cyc(1'b1, 2'd1, 3'd6, 1'b1, 8'h40, 11'h55, 16'h1234, 8'h00);
    cyc(1'b1, 2'd3, 3'd7, 1'b1, 8'h40, 11'h55, 16'h1234, 8'h00);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] l;
      l = 2'(1 + ($urandom % 3));
      cyc(($urandom % 4) != 0, l, 3'($urandom % 8), 1'($urandom),
          8'($urandom), 11'($urandom), 16'($urandom), 8'($urandom));
    end
    @(negedge clk);
    check("R8", "pc final", pc, pc_m);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule